// File: doc/BRIEF.md
# Lane Alignment Sequence Generator

This block produces the alignment sequence that a serial converter lane sends once code-group synchronisation is done and before user data begins. After a start pulse it emits one octet per clock for a programmable number of multiframes. Each octet comes with a flag that marks it as a control character for the 8b/10b encoder that follows. Every multiframe opens and closes with a control marker. The second multiframe also carries a lane-data marker, followed by fourteen packed configuration octets that end with a checksum.

The multiframe length is given in octets, which is frames per multiframe times octets per frame. The caller supplies it together with the number of multiframes and the link parameters. The block captures all of these when the start is accepted. Octets that are neither markers nor configuration carry a ramp. A one-cycle done pulse tells the lane that it may switch to user data.

Top module: `lane_align_gen`

## Requirements
- R1: While reset is held and after it is released, `out_valid`, `out_ctrl`, `seq_done` and `seq_busy` are 0 until a start is accepted.
- R2: The first octet of every multiframe is 0x1C with `out_ctrl` = 1.
- R3: The last octet of every multiframe, at index `mf_len`-1, is 0x7C with `out_ctrl` = 1.
- R4: Octet index 1 of the second multiframe (multiframe index 1) is 0x9C with `out_ctrl` = 1.
- R5: Octet indices 2 to 15 of the second multiframe carry configuration octets 0 to 13 with `out_ctrl` = 0, laid out as follows:
  - 0 = device id.
  - 1 = {adjust count[3:0], bank id[3:0]}.
  - 2 = {0, adjust direction, phase adjust, lane id[4:0]}.
  - 3 = {scrambling, 00, lanes[4:0]}.
  - 4 = octets per frame.
  - 5 = {000, frames per multiframe[4:0]}.
  - 6 = converters.
  - 7 = {control bits[1:0], 0, resolution[4:0]}.
  - 8 = {subclass[2:0], bits per sample[4:0]}.
  - 9 = {version[2:0], samples per frame[4:0]}.
  - 10 = {high density, 00, control words[4:0]}.
  - 11 and 12 = 0x00.
  - 13 = checksum.
- R6: Lanes, octets per frame, frames per multiframe, converters, resolution, bits per sample and samples per frame are sent as their value minus one, truncated to the field width. All other fields are sent unchanged.
- R7: The checksum is the sum of all transmitted field values, taken modulo 256. Each field counts as a value, not as a packed octet.
- R8: Every other octet carries the low 8 bits of its index within its multiframe, with `out_ctrl` = 0.
- R9: A sequence is exactly `mf_count` × `mf_len` consecutive cycles with `out_valid` = 1. Both `mf_count` (4 to 256) and `mf_len` (17 or more) are programmable.
- R10: `seq_done` is high for exactly the one cycle after the final 0x7C, and `seq_busy` is low in that cycle.
- R11: A start pulse while a sequence is in progress is ignored.
- R12: `mf_len`, `mf_count` and the configuration fields are captured when a start is accepted. Later changes to them do not affect that sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sequence (accepted only when idle) |
| mf_len | input | MF_LEN_W | Octets per multiframe |
| mf_count | input | MF_CNT_W | Number of multiframes |
| dev_id | input | 8 | Device identifier |
| bank_id | input | 4 | Bank identifier |
| adj_cnt | input | 4 | Adjustment step count |
| adj_dir | input | 1 | Adjustment direction |
| ph_adj | input | 1 | Phase adjust request |
| lane_id | input | 5 | Lane number within link |
| scr_en | input | 1 | Scrambling enabled |
| lanes | input | 6 | Lanes per link, 1 to 32 |
| oct_per_frm | input | 9 | Octets per frame, 1 to 256 |
| frm_per_mf | input | 6 | Frames per multiframe, 1 to 32 |
| conv_cnt | input | 9 | Converters, 1 to 256 |
| ctrl_bits | input | 2 | Control bits per sample |
| conv_res | input | 6 | Resolution, 1 to 32 |
| bits_per_smp | input | 6 | Total bits per sample, 1 to 32 |
| subclass | input | 3 | Device subclass |
| version | input | 3 | Protocol version |
| smp_per_frm | input | 6 | Samples per converter per frame, 1 to 32 |
| hi_dens | input | 1 | High density format |
| ctrl_words | input | 5 | Control words per frame |
| out_valid | output | 1 | Octet valid |
| out_octet | output | 8 | Octet value |
| out_ctrl | output | 1 | Octet is a control character |
| seq_busy | output | 1 | Sequence in progress |
| seq_done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that a start is accepted only with `mf_len` of at least 17, so that the configuration octets and the closing marker never overlap. They also assume `mf_count` lies between 4 and 256, and one assertion states this assumption. The stimulus sweeps multiframe lengths from 17 up to lengths above 256, uses counts of 4, 5, 6 and 256, and picks configuration values that include the range ends of the value-minus-one fields. Inputs are disturbed only inside that legal range, including a mid-sequence start and mid-sequence parameter changes.

// File: rtl/lag_pkg.sv
package lag_pkg;

    localparam logic [7:0] MARK_MF_OPEN  = 8'h1C;
    localparam logic [7:0] MARK_MF_CLOSE = 8'h7C;
    localparam logic [7:0] MARK_CFG_LEAD = 8'h9C;
    localparam int         CFG_OCTETS    = 14;
    localparam int         CFG_FIRST_POS = 2;
    localparam int         CFG_LAST_POS  = CFG_FIRST_POS + CFG_OCTETS - 1;
    localparam int         CFG_MF_INDEX  = 1;

    typedef struct packed {
        logic [7:0] dev_id;
        logic [3:0] bank_id;
        logic [3:0] adj_cnt;
        logic       adj_dir;
        logic       ph_adj;
        logic [4:0] lane_id;
        logic       scr_en;
        logic [5:0] lanes;
        logic [8:0] oct_per_frm;
        logic [5:0] frm_per_mf;
        logic [8:0] conv_cnt;
        logic [1:0] ctrl_bits;
        logic [5:0] conv_res;
        logic [5:0] bits_per_smp;
        logic [2:0] subclass;
        logic [2:0] version;
        logic [5:0] smp_per_frm;
        logic       hi_dens;
        logic [4:0] ctrl_words;
    } link_cfg_t;

    typedef enum logic [2:0] {
        SLOT_DATA,
        SLOT_OPEN,
        SLOT_CLOSE,
        SLOT_LEAD,
        SLOT_CFG
    } slot_t;

    typedef struct packed {
        logic [7:0] data;
        logic       ctrl;
    } lane_octet_t;

    function automatic logic [4:0] dec5(input logic [5:0] v);
        logic [5:0] t;
        t = v - 6'd1;
        return t[4:0];
    endfunction

    function automatic logic [7:0] dec8(input logic [8:0] v);
        logic [8:0] t;
        t = v - 9'd1;
        return t[7:0];
    endfunction

    function automatic logic [7:0] cfg_sum(input link_cfg_t c);
        logic [7:0] s;
        s = c.dev_id;
        s = s + 8'(c.bank_id)   + 8'(c.adj_cnt) + 8'(c.adj_dir) + 8'(c.ph_adj);
        s = s + 8'(c.lane_id)   + 8'(c.scr_en)  + 8'(dec5(c.lanes));
        s = s + dec8(c.oct_per_frm) + 8'(dec5(c.frm_per_mf)) + dec8(c.conv_cnt);
        s = s + 8'(c.ctrl_bits) + 8'(dec5(c.conv_res)) + 8'(dec5(c.bits_per_smp));
        s = s + 8'(c.subclass)  + 8'(c.version) + 8'(dec5(c.smp_per_frm));
        s = s + 8'(c.hi_dens)   + 8'(c.ctrl_words);
        return s;
    endfunction

    function automatic logic [7:0] cfg_octet(input link_cfg_t c, input logic [7:0] sum,
                                             input logic [3:0] idx);
        logic [7:0] o;
        case (idx)
            4'd0:    o = c.dev_id;
            4'd1:    o = {c.adj_cnt, c.bank_id};
            4'd2:    o = {1'b0, c.adj_dir, c.ph_adj, c.lane_id};
            4'd3:    o = {c.scr_en, 2'b00, dec5(c.lanes)};
            4'd4:    o = dec8(c.oct_per_frm);
            4'd5:    o = {3'b000, dec5(c.frm_per_mf)};
            4'd6:    o = dec8(c.conv_cnt);
            4'd7:    o = {c.ctrl_bits, 1'b0, dec5(c.conv_res)};
            4'd8:    o = {c.subclass, dec5(c.bits_per_smp)};
            4'd9:    o = {c.version, dec5(c.smp_per_frm)};
            4'd10:   o = {c.hi_dens, 2'b00, c.ctrl_words};
            4'd13:   o = sum;
            default: o = 8'h00;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/lag_seq_ctr.sv
module lag_seq_ctr #(
    parameter int MF_LEN_W = 10,
    parameter int MF_CNT_W = 9
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [MF_LEN_W-1:0] mf_len,
    input  logic [MF_CNT_W-1:0] mf_count,
    output logic                load,
    output logic                busy,
    output logic                done,
    output logic                mf_end,
    output logic [MF_LEN_W-1:0] pos,
    output logic [MF_CNT_W-1:0] mf_idx
);
    logic [MF_LEN_W-1:0] len_q;
    logic [MF_CNT_W-1:0] cnt_q;
    logic                seq_end;

    assign load    = start && !busy;
    assign mf_end  = (pos == len_q - 1'b1);
    assign seq_end = mf_end && (mf_idx == cnt_q - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            pos    <= '0;
            mf_idx <= '0;
            len_q  <= '0;
            cnt_q  <= '0;
        end else begin
            done <= 1'b0;
            if (load) begin
                busy   <= 1'b1;
                pos    <= '0;
                mf_idx <= '0;
                len_q  <= mf_len;
                cnt_q  <= mf_count;
            end else if (busy) begin
                if (mf_end) begin
                    pos    <= '0;
                    mf_idx <= mf_idx + 1'b1;
                    if (seq_end) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end
                end else begin
                    pos <= pos + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/lag_cfg_store.sv
module lag_cfg_store
    import lag_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  link_cfg_t  cfg_in,
    input  logic [3:0] idx,
    output logic [7:0] octet
);
    link_cfg_t  cfg_q;
    logic [7:0] sum_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            sum_q <= '0;
        end else if (load) begin
            cfg_q <= cfg_in;
            sum_q <= cfg_sum(cfg_in);
        end
    end

    assign octet = cfg_octet(cfg_q, sum_q, idx);
endmodule

// File: rtl/lag_octet_mux.sv
module lag_octet_mux
    import lag_pkg::*;
#(
    parameter int MF_LEN_W = 10,
    parameter int MF_CNT_W = 9
) (
    input  logic                busy,
    input  logic                mf_end,
    input  logic [MF_LEN_W-1:0] pos,
    input  logic [MF_CNT_W-1:0] mf_idx,
    input  logic [7:0]          cfg_byte,
    output logic [3:0]          cfg_idx,
    output lane_octet_t         oct
);
    localparam logic [MF_LEN_W-1:0] P_FIRST = MF_LEN_W'(CFG_FIRST_POS);
    localparam logic [MF_LEN_W-1:0] P_LAST  = MF_LEN_W'(CFG_LAST_POS);
    localparam logic [MF_CNT_W-1:0] CFG_MF  = MF_CNT_W'(CFG_MF_INDEX);

    slot_t               slot;
    logic [MF_LEN_W-1:0] rel;

    assign rel     = pos - P_FIRST;
    assign cfg_idx = rel[3:0];

    always_comb begin
        if (pos == '0)
            slot = SLOT_OPEN;
        else if (mf_end)
            slot = SLOT_CLOSE;
        else if (mf_idx == CFG_MF && pos == MF_LEN_W'(1))
            slot = SLOT_LEAD;
        else if (mf_idx == CFG_MF && pos >= P_FIRST && pos <= P_LAST)
            slot = SLOT_CFG;
        else
            slot = SLOT_DATA;
    end

    always_comb begin
        oct = '0;
        if (busy) begin
            case (slot)
                SLOT_OPEN:  oct = '{data: MARK_MF_OPEN,  ctrl: 1'b1};
                SLOT_CLOSE: oct = '{data: MARK_MF_CLOSE, ctrl: 1'b1};
                SLOT_LEAD:  oct = '{data: MARK_CFG_LEAD, ctrl: 1'b1};
                SLOT_CFG:   oct = '{data: cfg_byte,      ctrl: 1'b0};
                default:    oct = '{data: pos[7:0],      ctrl: 1'b0};
            endcase
        end
    end
endmodule

// File: rtl/lane_align_gen.sv
module lane_align_gen
    import lag_pkg::*;
#(
    parameter int MF_LEN_W = 10,
    parameter int MF_CNT_W = 9
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [MF_LEN_W-1:0] mf_len,
    input  logic [MF_CNT_W-1:0] mf_count,
    input  logic [7:0]          dev_id,
    input  logic [3:0]          bank_id,
    input  logic [3:0]          adj_cnt,
    input  logic                adj_dir,
    input  logic                ph_adj,
    input  logic [4:0]          lane_id,
    input  logic                scr_en,
    input  logic [5:0]          lanes,
    input  logic [8:0]          oct_per_frm,
    input  logic [5:0]          frm_per_mf,
    input  logic [8:0]          conv_cnt,
    input  logic [1:0]          ctrl_bits,
    input  logic [5:0]          conv_res,
    input  logic [5:0]          bits_per_smp,
    input  logic [2:0]          subclass,
    input  logic [2:0]          version,
    input  logic [5:0]          smp_per_frm,
    input  logic                hi_dens,
    input  logic [4:0]          ctrl_words,
    output logic                out_valid,
    output logic [7:0]          out_octet,
    output logic                out_ctrl,
    output logic                seq_busy,
    output logic                seq_done
);
    link_cfg_t           cfg_in;
    lane_octet_t         oct;
    logic                load, busy, done, mf_end;
    logic [MF_LEN_W-1:0] pos;
    logic [MF_CNT_W-1:0] mf_idx;
    logic [3:0]          cfg_idx;
    logic [7:0]          cfg_byte;

    assign cfg_in = '{dev_id: dev_id, bank_id: bank_id, adj_cnt: adj_cnt,
                      adj_dir: adj_dir, ph_adj: ph_adj, lane_id: lane_id,
                      scr_en: scr_en, lanes: lanes, oct_per_frm: oct_per_frm,
                      frm_per_mf: frm_per_mf, conv_cnt: conv_cnt,
                      ctrl_bits: ctrl_bits, conv_res: conv_res,
                      bits_per_smp: bits_per_smp, subclass: subclass,
                      version: version, smp_per_frm: smp_per_frm,
                      hi_dens: hi_dens, ctrl_words: ctrl_words};

    lag_seq_ctr #(.MF_LEN_W(MF_LEN_W), .MF_CNT_W(MF_CNT_W)) u_ctr (
        .clk(clk), .rst(rst), .start(start), .mf_len(mf_len),
        .mf_count(mf_count), .load(load), .busy(busy), .done(done),
        .mf_end(mf_end), .pos(pos), .mf_idx(mf_idx)
    );

    lag_cfg_store u_cfg (
        .clk(clk), .rst(rst), .load(load), .cfg_in(cfg_in),
        .idx(cfg_idx), .octet(cfg_byte)
    );

    lag_octet_mux #(.MF_LEN_W(MF_LEN_W), .MF_CNT_W(MF_CNT_W)) u_mux (
        .busy(busy), .mf_end(mf_end), .pos(pos), .mf_idx(mf_idx),
        .cfg_byte(cfg_byte), .cfg_idx(cfg_idx), .oct(oct)
    );

    assign out_valid = busy;
    assign out_octet = oct.data;
    assign out_ctrl  = oct.ctrl;
    assign seq_busy  = busy;
    assign seq_done  = done;
endmodule

// File: rtl/lag_chk.sv
module lag_chk #(
    parameter int MF_LEN_W = 10,
    parameter int MF_CNT_W = 9
) (
    input logic                clk,
    input logic                rst,
    input logic                start,
    input logic [MF_LEN_W-1:0] mf_len,
    input logic [MF_CNT_W-1:0] mf_count,
    input logic                out_valid,
    input logic [7:0]          out_octet,
    input logic                out_ctrl,
    input logic                seq_busy,
    input logic                seq_done
);
    assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (rst)
        !seq_busy |-> !out_valid && !out_ctrl);

    assert_ctrl_set_R2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ctrl) |->
        (out_octet == 8'h1C || out_octet == 8'h7C || out_octet == 8'h9C));

    assert_open_follows_close_R11: assert property (@(posedge clk) disable iff (rst)
        ($past(out_valid) && out_valid && out_ctrl && out_octet == 8'h1C) |->
        ($past(out_ctrl) && $past(out_octet) == 8'h7C));

    assert_close_then_open_R3: assert property (@(posedge clk) disable iff (rst)
        ($past(out_valid) && $past(out_ctrl) && $past(out_octet) == 8'h7C) |->
        ((out_valid && out_ctrl && out_octet == 8'h1C) || seq_done));

    assert_lead_after_open_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ctrl && out_octet == 8'h9C) |->
        ($past(out_ctrl) && $past(out_octet) == 8'h1C));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
        seq_done |=> !seq_done);

    assert_done_after_close_R10: assert property (@(posedge clk) disable iff (rst)
        seq_done |-> (!seq_busy && $past(out_valid) && $past(out_ctrl) &&
                      $past(out_octet) == 8'h7C));

    assert_legal_lengths_R9: assert property (@(posedge clk) disable iff (rst)
        (start && !seq_busy) |->
        (mf_len >= MF_LEN_W'(17) && mf_count >= MF_CNT_W'(4) &&
         32'(mf_count) <= 256));
endmodule

bind lane_align_gen lag_chk #(.MF_LEN_W(MF_LEN_W), .MF_CNT_W(MF_CNT_W)) u_chk (
    .clk(clk), .rst(rst), .start(start), .mf_len(mf_len), .mf_count(mf_count),
    .out_valid(out_valid), .out_octet(out_octet), .out_ctrl(out_ctrl),
    .seq_busy(seq_busy), .seq_done(seq_done)
);

// File: tb/sim_lane_align_gen.sv
module sim_lane_align_gen;
    import lag_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int LW = 10;
    localparam int CW = 9;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [LW-1:0] mf_len = LW'(17);
    logic [CW-1:0] mf_count = CW'(4);
    link_cfg_t     d = '0;
    logic          out_valid, out_ctrl, seq_busy, seq_done;
    logic [7:0]    out_octet;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_align_gen #(.MF_LEN_W(LW), .MF_CNT_W(CW)) u0 (
        .clk(clk), .rst(rst), .start(start), .mf_len(mf_len), .mf_count(mf_count),
        .dev_id(d.dev_id), .bank_id(d.bank_id), .adj_cnt(d.adj_cnt),
        .adj_dir(d.adj_dir), .ph_adj(d.ph_adj), .lane_id(d.lane_id),
        .scr_en(d.scr_en), .lanes(d.lanes), .oct_per_frm(d.oct_per_frm),
        .frm_per_mf(d.frm_per_mf), .conv_cnt(d.conv_cnt), .ctrl_bits(d.ctrl_bits),
        .conv_res(d.conv_res), .bits_per_smp(d.bits_per_smp), .subclass(d.subclass),
        .version(d.version), .smp_per_frm(d.smp_per_frm), .hi_dens(d.hi_dens),
        .ctrl_words(d.ctrl_words), .out_valid(out_valid), .out_octet(out_octet),
        .out_ctrl(out_ctrl), .seq_busy(seq_busy), .seq_done(seq_done)
    );

    task automatic check(string req, int act, int exp, string what);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int m1(int v, int modv);
        return (v - 1 + modv) % modv;
    endfunction

    function automatic int field_sum(link_cfg_t c);
        int s;
        s = c.dev_id + c.bank_id + c.adj_cnt + c.adj_dir + c.ph_adj + c.lane_id
          + c.scr_en + m1(c.lanes, 32) + m1(c.oct_per_frm, 256) + m1(c.frm_per_mf, 32)
          + m1(c.conv_cnt, 256) + c.ctrl_bits + m1(c.conv_res, 32)
          + m1(c.bits_per_smp, 32) + c.subclass + c.version + m1(c.smp_per_frm, 32)
          + c.hi_dens + c.ctrl_words;
        return s % 256;
    endfunction

    function automatic int exp_cfg(link_cfg_t c, int b);
        case (b)
            0:  return c.dev_id;
            1:  return c.adj_cnt * 16 + c.bank_id;
            2:  return c.adj_dir * 64 + c.ph_adj * 32 + c.lane_id;
            3:  return c.scr_en * 128 + m1(c.lanes, 32);
            4:  return m1(c.oct_per_frm, 256);
            5:  return m1(c.frm_per_mf, 32);
            6:  return m1(c.conv_cnt, 256);
            7:  return c.ctrl_bits * 64 + m1(c.conv_res, 32);
            8:  return c.subclass * 32 + m1(c.bits_per_smp, 32);
            9:  return c.version * 32 + m1(c.smp_per_frm, 32);
            10: return c.hi_dens * 128 + c.ctrl_words;
            13: return field_sum(c);
            default: return 0;
        endcase
    endfunction

    task automatic set_cfg(int s);
        d.dev_id       = 8'(s * 37 + 5);
        d.bank_id      = 4'(s * 3);
        d.adj_cnt      = 4'(s + 7);
        d.adj_dir      = 1'(s);
        d.ph_adj       = 1'(s >> 1);
        d.lane_id      = 5'(s * 5);
        d.scr_en       = 1'(s >> 2);
        d.lanes        = 6'(s % 32 + 1);
        d.oct_per_frm  = 9'((s * 71) % 256 + 1);
        d.frm_per_mf   = 6'((s * 13) % 32 + 1);
        d.conv_cnt     = 9'((s * 29) % 256 + 1);
        d.ctrl_bits    = 2'(s);
        d.conv_res     = 6'((s * 7) % 32 + 1);
        d.bits_per_smp = 6'((s * 11) % 32 + 1);
        d.subclass     = 3'(s);
        d.version      = 3'(s + 1);
        d.smp_per_frm  = 6'((s * 17) % 32 + 1);
        d.hi_dens      = 1'(s >> 3);
        d.ctrl_words   = 5'(s * 9);
    endtask

    task automatic set_max();
        d = '{dev_id: 8'hFF, bank_id: 4'hF, adj_cnt: 4'hF, adj_dir: 1'b1, ph_adj: 1'b1,
              lane_id: 5'h1F, scr_en: 1'b1, lanes: 6'd32, oct_per_frm: 9'd256,
              frm_per_mf: 6'd32, conv_cnt: 9'd256, ctrl_bits: 2'd3, conv_res: 6'd32,
              bits_per_smp: 6'd32, subclass: 3'd7, version: 3'd7, smp_per_frm: 6'd32,
              hi_dens: 1'b1, ctrl_words: 5'h1F};
    endtask

    // Runs one sequence; with disturb set, a second start and new inputs arrive mid-run.
    task automatic run_seq(int len, int cnt, bit disturb);
        link_cfg_t e;
        int total, nvalid, bad, p, mf, eo, ek;
        string req;
        e = d;
        total = len * cnt;
        nvalid = 0;
        bad = 0;
        mf_len = LW'(len);
        mf_count = CW'(cnt);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < total; i++) begin
            p = i % len;
            mf = i / len;
            if (p == 0) begin
                eo = 8'h1C; ek = 1; req = "R2";
            end else if (p == len - 1) begin
                eo = 8'h7C; ek = 1; req = "R3";
            end else if (mf == 1 && p == 1) begin
                eo = 8'h9C; ek = 1; req = "R4";
            end else if (mf == 1 && p >= 2 && p <= 15) begin
                eo = exp_cfg(e, p - 2); ek = 0;
                req = (p == 15) ? "R7" : ((p - 2) inside {3, 4, 5, 6, 7, 8, 9}) ? "R6" : "R5";
            end else begin
                eo = p % 256; ek = 0; req = "R8";
            end
            if (out_valid) nvalid++;
            if (out_octet != 8'(eo) || out_ctrl != 1'(ek)) bad++;
            check(req, int'(out_octet), eo, $sformatf("octet mf%0d pos%0d", mf, p));
            check(req, int'(out_ctrl), ek, $sformatf("ctrl mf%0d pos%0d", mf, p));
            if (disturb && i == 5) begin
                start = 1'b1;
                mf_len = LW'(len + 3);
                mf_count = CW'(cnt + 1);
                set_cfg(99);
            end
            if (disturb && i == 6) start = 1'b0;
            @(negedge clk);
        end
        check("R9", nvalid, total, "valid octet count");
        check("R10", int'(seq_done), 1, "done after last octet");
        check("R10", int'(seq_busy), 0, "busy in done cycle");
        check("R9", int'(out_valid), 0, "valid after sequence");
        if (disturb) begin
            check("R11", nvalid, total, "length with mid-run start");
            check("R12", bad, 0, "mismatches after mid-run input change");
        end
        @(negedge clk);
        check("R10", int'(seq_done), 0, "done lasts one cycle");
        d = e;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        set_cfg(1);
        repeat (3) @(negedge clk);
        check("R1", int'(out_valid), 0, "valid in reset");
        check("R1", int'(seq_busy), 0, "busy in reset");
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check("R1", int'(out_valid), 0, "valid after reset");
        check("R1", int'(seq_done), 0, "done after reset");
        check("R1", int'(out_ctrl), 0, "ctrl after reset");

        run_seq(17, 4, 1'b0);
        set_max();
        run_seq(32, 5, 1'b0);
        set_cfg(3);
        run_seq(20, 6, 1'b1);
        for (int s = 0; s < 12; s++) begin
            set_cfg(s + 4);
            run_seq(17 + s, 4, 1'b0);
        end
        set_cfg(7);
        run_seq(300, 4, 1'b0);
        set_cfg(11);
        run_seq(17, 256, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule